// File: doc/BRIEF.md
# Coherent Byte-Access SPI Word Registers

This block is the register front end between an 8-bit processor bus and a 16-bit serial shift engine. The processor sees four byte-wide locations: the low and high bytes of the data word and the low and high bytes of a compare word. The shift engine delivers each received word with a one-cycle completion strobe and takes the outgoing word from a transmit buffer whenever it starts a transfer.

Because the processor moves one byte per access, the block keeps 16-bit values whole. The first byte read of a pair freezes both bytes in a read latch until the partner byte is read. Byte writes collect in a write latch, and the full word moves into the transmit buffer or the compare register in one step. Each accepted received word is compared against the compare register and raises a match flag on equality. A receive-full flag, an overrun flag and a transmit-empty flag report buffer state to the rest of the chip.

A mode input selects narrow (8-bit) or wide (16-bit) operation. In narrow mode only the low bytes are active and a single low-byte write loads a register directly.

Top module: `spi_word_regs`

## Requirements
- R1: After reset the receive-full, overrun and match flags are 0, the transmit-empty flag is 1, the transmit word is 0, and both compare bytes read back as 0.
- R2: A completion strobe while receive-full is 0 stores the received word and sets receive-full at the next clock edge.
- R3: A completion strobe while receive-full is 1, with no receive-completing read in the same cycle, sets overrun and leaves the receive buffer unchanged.
- R4: In narrow mode (mode input 0) reads of the data high byte (select 1) and the compare high byte (select 3) return 0, and writes to them change neither the transmit word nor the compare value.
- R5: In wide mode the first read of either byte of a pair (data: selects 0/1, compare: selects 2/3) captures the whole word; later reads of that pair return the captured word until its other byte is read.
- R6: Receive-full is cleared by the read that completes access to the data: a select-0 read in narrow mode, or the second byte of a captured data pair in wide mode. The first byte of a pair and compare reads leave it set.
- R7: In wide mode a data-byte write (select 0 low, select 1 high) changes the transmit word only once both bytes are written, in either order; a repeated write to the same byte overwrites the held byte.
- R8: In narrow mode a select-0 write loads the transmit word with the byte in the low half and zero in the high half.
- R9: The compare register (select 2 low, select 3 high) follows the same gathering as the data word: in wide mode a new value takes effect only after both bytes are written, in narrow mode a select-2 write loads it at once.
- R10: The match flag is set when a word is accepted into the receive buffer and equals the compare value (all 16 bits in wide mode, only the low 8 bits in narrow mode); mismatching or discarded words do not set it.
- R11: The overrun-clear and match-clear strobes clear their flags at the next edge; a set condition in the same cycle wins over the clear.
- R12: Transmit-empty goes to 0 at the edge after a full word is loaded into the transmit buffer and to 1 at the edge after the shift engine takes the buffer; a load wins over a take.
- R13: A change of the mode input clears every partly written and partly read pair, so a byte from before the change is never combined with one after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| bus_sel | input | 2 | Byte select: 0 data low, 1 data high, 2 compare low, 3 compare high |
| bus_rd | input | 1 | Read strobe for the selected byte |
| bus_wr | input | 1 | Write strobe for the selected byte |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, valid in the cycle of the read strobe |
| xfer_done | input | 1 | Shift engine finished a transfer |
| rx_word | input | 16 | Word received by the shift engine |
| tx_take | input | 1 | Shift engine takes the transmit buffer |
| tx_word | output | 16 | Transmit buffer contents |
| tx_empty | output | 1 | Transmit buffer has been handed over |
| rx_full | output | 1 | Receive buffer holds an unread word |
| overrun | output | 1 | A word arrived while the buffer was still full |
| match_hit | output | 1 | An accepted word equalled the compare value |
| ovr_clr | input | 1 | Clear strobe for overrun |
| match_clr | input | 1 | Clear strobe for match_hit |

## Verification
Read data is combinational and due in the same cycle as the read strobe, so the bench samples bus_rdata one nanosecond after it drives the strobe at the falling edge, before the rising edge that updates the latches. Every flag, the transmit word and the compare value are registered once and are due at the first rising edge after the strobe; each stimulus task raises its strobe at a falling edge, waits for one rising edge, drops it and samples one nanosecond later. Mode changes are held for one full cycle before any access so the flush edge has passed.

// File: rtl/spi_word_regs_pkg.sv
// Package: shared byte-select encoding for the SPI word register block.
// Assumes a 2-bit select with one location per byte of each 16-bit word.
package spi_word_regs_pkg;

    typedef enum logic [1:0] {
        SEL_DATA_LO  = 2'd0,
        SEL_DATA_HI  = 2'd1,
        SEL_MATCH_LO = 2'd2,
        SEL_MATCH_HI = 2'd3
    } byte_sel_e;

    localparam int unsigned NUM_PAIRS = 2;   // data pair and compare pair
    localparam int unsigned PAIR_DATA  = 0;
    localparam int unsigned PAIR_MATCH = 1;

endpackage

// File: rtl/swr_read_latch.sv
// Module: swr_read_latch
// Presents one 16-bit word as two bytes. In wide mode the first byte read
// freezes the word; the freeze ends when the partner byte is read.
// Assumes at most one of rd_lo / rd_hi per cycle and no access while flush.
module swr_read_latch #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                wide,
    input  logic                rd_lo,
    input  logic                rd_hi,
    input  logic [2*BYTE_W-1:0] live_word,
    output logic [BYTE_W-1:0]   lo_byte,
    output logic [BYTE_W-1:0]   hi_byte,
    output logic                rd_done
);
    localparam int unsigned WORD_W = 2 * BYTE_W;

    logic              held;
    logic              pend_hi;
    logic [WORD_W-1:0] held_word;
    logic [WORD_W-1:0] src_word;

    // Pick the frozen word while a pair is open, otherwise the live one.
    always_comb begin
        src_word = held ? held_word : live_word;
        if (wide) begin
            lo_byte = src_word[BYTE_W-1:0];
            hi_byte = src_word[WORD_W-1:BYTE_W];
        end else begin
            lo_byte = live_word[BYTE_W-1:0];
            hi_byte = '0;
        end
    end

    // Flag the read that finishes access to the word.
    always_comb begin
        if (flush)
            rd_done = 1'b0;
        else if (wide)
            rd_done = held && ((pend_hi && rd_hi) || (!pend_hi && rd_lo));
        else
            rd_done = rd_lo;
    end

    // Open the pair on a first read, close it on the partner read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held      <= 1'b0;
            pend_hi   <= 1'b0;
            held_word <= '0;
        end else if (flush || !wide) begin
            held      <= 1'b0;
        end else if (!held && (rd_lo || rd_hi)) begin
            held      <= 1'b1;
            held_word <= live_word;
            pend_hi   <= rd_lo;
        end else if (rd_done) begin
            held      <= 1'b0;
        end
    end

    AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(held_word)) else $error("frozen word changed"); // R5

    AST_NARROW_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |=> !held) else $error("pair open in narrow mode"); // R13

endmodule

// File: rtl/swr_write_gather.sv
// Module: swr_write_gather
// Collects two byte writes into one word and issues a single load pulse.
// In narrow mode a low-byte write loads at once and high writes are dropped.
// Assumes at most one of wr_lo / wr_hi per cycle.
module swr_write_gather #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                wide,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wdata,
    output logic                load,
    output logic [2*BYTE_W-1:0] load_word
);
    localparam int unsigned WORD_W = 2 * BYTE_W;

    logic              got_lo;
    logic              got_hi;
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    // Decide whether this write completes a word and what that word is.
    always_comb begin
        load      = 1'b0;
        load_word = {hi_q, lo_q};
        if (flush) begin
            load = 1'b0;
        end else if (!wide) begin
            load      = wr_lo;
            load_word = {{BYTE_W{1'b0}}, wdata};
        end else if (wr_lo) begin
            load      = got_hi;
            load_word = {hi_q, wdata};
        end else if (wr_hi) begin
            load      = got_lo;
            load_word = {wdata, lo_q};
        end
    end

    // Hold partial bytes until the word completes or the mode changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_lo <= 1'b0;
            got_hi <= 1'b0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else if (flush || !wide || load) begin
            got_lo <= 1'b0;
            got_hi <= 1'b0;
        end else if (wr_lo) begin
            got_lo <= 1'b1;
            lo_q   <= wdata;
        end else if (wr_hi) begin
            got_hi <= 1'b1;
            hi_q   <= wdata;
        end
    end

    AST_NO_BOTH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> !(got_lo && got_hi)) else $error("both halves pending"); // R7

    AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !got_lo && !got_hi) else $error("partial survived flush"); // R13

endmodule

// File: rtl/swr_rx_track.sv
// Module: swr_rx_track
// Owns the receive buffer and the full, overrun and match flags.
// Assumes xfer_done is a single-cycle strobe from the shift engine.
module swr_rx_track #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wide,
    input  logic                xfer_done,
    input  logic [2*BYTE_W-1:0] rx_word,
    input  logic                rd_done,
    input  logic [2*BYTE_W-1:0] match_word,
    input  logic                ovr_clr,
    input  logic                match_clr,
    output logic [2*BYTE_W-1:0] rx_buf,
    output logic                rx_full,
    output logic                overrun,
    output logic                match_hit
);
    logic accept;
    logic equal;

    // A word is taken if the buffer is free or is being emptied now.
    always_comb begin
        accept = xfer_done && (!rx_full || rd_done);
        if (wide)
            equal = (rx_word == match_word);
        else
            equal = (rx_word[BYTE_W-1:0] == match_word[BYTE_W-1:0]);
    end

    // Store accepted words and keep the receive-full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            rx_full <= 1'b0;
        end else if (accept) begin
            rx_buf  <= rx_word;
            rx_full <= 1'b1;
        end else if (rd_done) begin
            rx_full <= 1'b0;
        end
    end

    // Overrun and match flags: setting wins over the clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun   <= 1'b0;
            match_hit <= 1'b0;
        end else begin
            if (xfer_done && !accept)
                overrun <= 1'b1;
            else if (ovr_clr)
                overrun <= 1'b0;
            if (accept && equal)
                match_hit <= 1'b1;
            else if (match_clr)
                match_hit <= 1'b0;
        end
    end

    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && !rx_full |=> rx_full && rx_buf == $past(rx_word))
        else $error("word not stored"); // R2

    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done && rx_full && !rd_done |=> overrun && $stable(rx_buf))
        else $error("overrun handling"); // R3

    AST_MATCH_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_hit) |-> $past(xfer_done)) else $error("match without transfer"); // R10

endmodule

// File: rtl/spi_word_regs.sv
// Module: spi_word_regs (top)
// Byte-wide register front end for a 16-bit serial shift engine: coherent
// reads of receive and compare words, gathered writes of transmit and
// compare words, and receive status flags.
// Assumes one bus access per cycle and no access in the cycle the mode changes.
module spi_word_regs
    import spi_word_regs_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wide_mode,
    input  logic [1:0]          bus_sel,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic                xfer_done,
    input  logic [2*BYTE_W-1:0] rx_word,
    input  logic                tx_take,
    output logic [2*BYTE_W-1:0] tx_word,
    output logic                tx_empty,
    output logic                rx_full,
    output logic                overrun,
    output logic                match_hit,
    input  logic                ovr_clr,
    input  logic                match_clr
);
    localparam int unsigned WORD_W = 2 * BYTE_W;

    logic              mode_q;
    logic              flush;
    logic [WORD_W-1:0] rx_buf;
    logic [WORD_W-1:0] match_reg;
    logic [WORD_W-1:0] live_w   [NUM_PAIRS];
    logic [BYTE_W-1:0] rd_lo_b  [NUM_PAIRS];
    logic [BYTE_W-1:0] rd_hi_b  [NUM_PAIRS];
    logic              rd_done  [NUM_PAIRS];
    logic              load_w   [NUM_PAIRS];
    logic [WORD_W-1:0] word_w   [NUM_PAIRS];
    logic              sel_lo   [NUM_PAIRS];
    logic              sel_hi   [NUM_PAIRS];

    // Track the mode so a change flushes all half-finished pairs.
    always_ff @(posedge clk) begin
        mode_q <= wide_mode;
    end
    assign flush = !rst_n || (wide_mode != mode_q);

    assign live_w[PAIR_DATA]  = rx_buf;
    assign live_w[PAIR_MATCH] = match_reg;
    assign sel_lo[PAIR_DATA]  = (bus_sel == SEL_DATA_LO);
    assign sel_hi[PAIR_DATA]  = (bus_sel == SEL_DATA_HI);
    assign sel_lo[PAIR_MATCH] = (bus_sel == SEL_MATCH_LO);
    assign sel_hi[PAIR_MATCH] = (bus_sel == SEL_MATCH_HI);

    // One read latch and one write gatherer per word pair.
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        swr_read_latch #(.BYTE_W(BYTE_W)) u_rd (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .wide      (wide_mode),
            .rd_lo     (bus_rd && sel_lo[g]),
            .rd_hi     (bus_rd && sel_hi[g]),
            .live_word (live_w[g]),
            .lo_byte   (rd_lo_b[g]),
            .hi_byte   (rd_hi_b[g]),
            .rd_done   (rd_done[g])
        );
        swr_write_gather #(.BYTE_W(BYTE_W)) u_wr (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .wide      (wide_mode),
            .wr_lo     (bus_wr && sel_lo[g]),
            .wr_hi     (bus_wr && sel_hi[g]),
            .wdata     (bus_wdata),
            .load      (load_w[g]),
            .load_word (word_w[g])
        );
    end

    // Receive buffer and status flags.
    swr_rx_track #(.BYTE_W(BYTE_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide       (wide_mode),
        .xfer_done  (xfer_done),
        .rx_word    (rx_word),
        .rd_done    (rd_done[PAIR_DATA]),
        .match_word (match_reg),
        .ovr_clr    (ovr_clr),
        .match_clr  (match_clr),
        .rx_buf     (rx_buf),
        .rx_full    (rx_full),
        .overrun    (overrun),
        .match_hit  (match_hit)
    );

    // Load the transmit buffer on a completed word; track its hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word  <= '0;
            tx_empty <= 1'b1;
        end else if (load_w[PAIR_DATA]) begin
            tx_word  <= word_w[PAIR_DATA];
            tx_empty <= 1'b0;
        end else if (tx_take) begin
            tx_empty <= 1'b1;
        end
    end

    // Load the compare register on a completed word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_reg <= '0;
        else if (load_w[PAIR_MATCH])
            match_reg <= word_w[PAIR_MATCH];
    end

    // Route the selected byte to the bus.
    always_comb begin
        case (byte_sel_e'(bus_sel))
            SEL_DATA_LO:  bus_rdata = rd_lo_b[PAIR_DATA];
            SEL_DATA_HI:  bus_rdata = rd_hi_b[PAIR_DATA];
            SEL_MATCH_LO: bus_rdata = rd_lo_b[PAIR_MATCH];
            default:      bus_rdata = rd_hi_b[PAIR_MATCH];
        endcase
    end

    AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load_w[PAIR_DATA] |=> $stable(tx_word)) else $error("tx word moved"); // R7

    AST_TX_EMPTY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_w[PAIR_DATA] |=> !tx_empty) else $error("empty after load"); // R12

    AST_MATCH_RD_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done[PAIR_MATCH] && !xfer_done |=> rx_full == $past(rx_full))
        else $error("compare read touched rx_full"); // R6

endmodule

// File: tb/spi_word_regs_bench.sv
`timescale 1ns/1ps
module spi_word_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b1;
    logic [1:0]  bus_sel = 2'd0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        xfer_done = 1'b0;
    logic [15:0] rx_word = 16'd0;
    logic        tx_take = 1'b0;
    logic [15:0] tx_word;
    logic        tx_empty;
    logic        rx_full;
    logic        overrun;
    logic        match_hit;
    logic        ovr_clr = 1'b0;
    logic        match_clr = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_word_regs u_spi_word_regs (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .bus_sel(bus_sel),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .xfer_done(xfer_done), .rx_word(rx_word),
        .tx_take(tx_take), .tx_word(tx_word), .tx_empty(tx_empty),
        .rx_full(rx_full), .overrun(overrun), .match_hit(match_hit),
        .ovr_clr(ovr_clr), .match_clr(match_clr)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [1:0] s, logic [7:0] d);
        @(negedge clk); bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] s, output logic [7:0] d);
        @(negedge clk); bus_sel = s; bus_rd = 1'b1; #1; d = bus_rdata;
        @(posedge clk); #1; bus_rd = 1'b0;
    endtask

    task automatic xfer(logic [15:0] w);
        @(negedge clk); rx_word = w; xfer_done = 1'b1;
        @(posedge clk); #1; xfer_done = 1'b0;
    endtask

    task automatic pulse_take();
        @(negedge clk); tx_take = 1'b1; @(posedge clk); #1; tx_take = 1'b0;
    endtask

    task automatic clr_flags();
        @(negedge clk); ovr_clr = 1'b1; match_clr = 1'b1;
        @(posedge clk); #1; ovr_clr = 1'b0; match_clr = 1'b0;
    endtask

    task automatic set_mode(logic m);
        @(negedge clk); wide_mode = m; cyc();
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        logic [15:0] prev;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        cyc();

        // R1 reset state
        check("R1 rx_full", {15'd0, rx_full}, 16'd0);
        check("R1 overrun", {15'd0, overrun}, 16'd0);
        check("R1 match", {15'd0, match_hit}, 16'd0);
        check("R1 tx_empty", {15'd0, tx_empty}, 16'd1);
        check("R1 tx_word", tx_word, 16'd0);
        rd(2'd3, b); check("R1 match hi", {8'd0, b}, 16'd0);
        rd(2'd2, b); check("R1 match lo", {8'd0, b}, 16'd0);

        // R7 / R12 wide write gathering, both orders
        for (int i = 0; i < 8; i++) begin
            w = 16'(i * 16'h1357) ^ 16'hA5C3;
            prev = tx_word;
            if (i % 2 == 0) begin
                wr(2'd1, w[15:8]);
                check("R7 half hi", tx_word, prev);
                wr(2'd0, w[7:0]);
            end else begin
                wr(2'd0, ~w[7:0]);
                wr(2'd0, w[7:0]);
                check("R7 half lo", tx_word, prev);
                wr(2'd1, w[15:8]);
            end
            check("R7 full word", tx_word, w);
            check("R12 empty low", {15'd0, tx_empty}, 16'd0);
            pulse_take();
            check("R12 empty after take", {15'd0, tx_empty}, 16'd1);
        end

        // R2 / R3 / R5 / R6 wide receive with latched pairs
        for (int i = 0; i < 8; i++) begin
            w = 16'(i * 16'h2F1B) + 16'h0101;
            xfer(w);
            check("R2 full", {15'd0, rx_full}, 16'd1);
            if (i % 2 == 0) begin
                rd(2'd1, b); check("R5 first hi", {8'd0, b}, {8'd0, w[15:8]});
                check("R6 first keeps full", {15'd0, rx_full}, 16'd1);
                xfer(w ^ 16'hFFFF);
                check("R3 overrun", {15'd0, overrun}, 16'd1);
                rd(2'd0, b); check("R3 kept lo", {8'd0, b}, {8'd0, w[7:0]});
                clr_flags();
                check("R11 ovr cleared", {15'd0, overrun}, 16'd0);
            end else begin
                rd(2'd0, b); check("R5 first lo", {8'd0, b}, {8'd0, w[7:0]});
                rd(2'd1, b); check("R5 second hi", {8'd0, b}, {8'd0, w[15:8]});
            end
            check("R6 cleared", {15'd0, rx_full}, 16'd0);
        end

        // R9 / R10 / R11 compare register in wide mode
        wr(2'd2, 8'h34); wr(2'd3, 8'h12);
        xfer(16'h1234);
        check("R10 wide hit", {15'd0, match_hit}, 16'd1);
        rd(2'd0, b); rd(2'd1, b);
        clr_flags();
        check("R11 match cleared", {15'd0, match_hit}, 16'd0);
        xfer(16'h1235);
        check("R10 wide miss", {15'd0, match_hit}, 16'd0);
        rd(2'd0, b); rd(2'd1, b);
        @(negedge clk); rx_word = 16'h1234; xfer_done = 1'b1; match_clr = 1'b1;
        @(posedge clk); #1; xfer_done = 1'b0; match_clr = 1'b0;
        check("R11 set wins", {15'd0, match_hit}, 16'd1);
        rd(2'd0, b); rd(2'd1, b);
        clr_flags();
        xfer(16'h1111); xfer(16'h1234);
        check("R10 discarded no hit", {15'd0, match_hit}, 16'd0);
        rd(2'd0, b); rd(2'd1, b);
        clr_flags();
        rd(2'd3, b); check("R5 match hi", {8'd0, b}, 16'h0012);
        wr(2'd2, 8'h78); wr(2'd3, 8'h56);
        rd(2'd2, b); check("R5 match lo latched", {8'd0, b}, 16'h0034);
        rd(2'd2, b); check("R9 new lo", {8'd0, b}, 16'h0078);
        rd(2'd3, b); check("R9 new hi", {8'd0, b}, 16'h0056);
        wr(2'd3, 8'h9A);
        xfer(16'h5678);
        check("R9 half write no effect", {15'd0, match_hit}, 16'd1);
        rd(2'd0, b); rd(2'd1, b); clr_flags();
        wr(2'd2, 8'hBC);
        xfer(16'h9ABC);
        check("R9 gathered", {15'd0, match_hit}, 16'd1);
        rd(2'd0, b); rd(2'd1, b); clr_flags();

        // R4 / R8 / R10 narrow mode
        set_mode(1'b0);
        wr(2'd0, 8'h3C);
        check("R8 narrow load", tx_word, 16'h003C);
        check("R12 narrow empty", {15'd0, tx_empty}, 16'd0);
        wr(2'd1, 8'h77);
        check("R4 hi write ignored", tx_word, 16'h003C);
        rd(2'd1, b); check("R4 data hi zero", {8'd0, b}, 16'd0);
        wr(2'd3, 8'hEE);
        rd(2'd3, b); check("R4 match hi zero", {8'd0, b}, 16'd0);
        wr(2'd2, 8'h5A);
        rd(2'd2, b); check("R9 narrow match", {8'd0, b}, 16'h005A);
        xfer(16'h125A);
        check("R10 narrow hit", {15'd0, match_hit}, 16'd1);
        rd(2'd0, b); check("R6 narrow lo", {8'd0, b}, 16'h005A);
        check("R6 narrow clear", {15'd0, rx_full}, 16'd0);
        clr_flags();
        xfer(16'h0011); xfer(16'h0022);
        check("R3 narrow overrun", {15'd0, overrun}, 16'd1);
        rd(2'd0, b); check("R3 narrow kept", {8'd0, b}, 16'h0011);
        clr_flags();
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v;
            v = 8'(i * 17);
            wr(2'd2, v);
            xfer({8'(i), v ^ {7'd0, 1'(i % 2)}});
            check("R10 narrow sweep", {15'd0, match_hit}, {15'd0, 1'(i % 2 == 0)});
            rd(2'd0, b);
            clr_flags();
        end

        // R13 mode change drops partial pairs
        set_mode(1'b1);
        wr(2'd1, 8'hAB);
        set_mode(1'b0);
        set_mode(1'b1);
        wr(2'd0, 8'hCD);
        check("R13 write flushed", tx_word, 16'h003C);
        wr(2'd1, 8'hEF);
        check("R13 fresh pair", tx_word, 16'hEFCD);
        xfer(16'h4321);
        rd(2'd1, b); check("R13 latch hi", {8'd0, b}, 16'h0043);
        set_mode(1'b0);
        set_mode(1'b1);
        rd(2'd0, b);
        check("R13 read flushed", {15'd0, rx_full}, 16'd1);
        rd(2'd1, b); check("R13 pair closes", {15'd0, rx_full}, 16'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule